// File: doc/BRIEF.md
# Multi-Channel Comparator Event Timer

A free-running 64-bit main counter feeds a small bank of comparator channels. A channel raises an interrupt level when the counter reaches the channel's comparator value. In one-shot mode it fires once. In periodic mode it fires again and again, because the comparator moves forward by a programmed period after each match. Software drives the block through a plain register port. Each write takes one cycle, and read data is a combinational function of the address. The port has no back-pressure: a write is taken on the clock edge where `bus_wr` is high, with no ready signal, and reads never stall.

Software starts time in this order: stop the counter, write zero to both halves, then set the global enable. A periodic channel is armed with a two-write sequence to the comparator's low address, after the set-value flag has been set: the first write places the comparator, and the second write sets the period. There is also a legacy routing mode. In that mode channel 0 drives a dedicated system-tick line and channel 1 drives a dedicated real-time-clock line. Every other channel goes to whichever general interrupt line its own route field selects.

Top module: `cmp_event_timer`

## Requirements
- R1: After reset the counter reads 0, the global configuration (word 2) reads 0, the status word (word 3) reads 0 and every interrupt output is low.
- R2: Word 0 is read-only and reads channel count minus one in bits [4:0] and 1 in bit 8 (legacy routing supported). Word 1 reads the constant tick length in femtoseconds (parameter TICK_FS, nonzero).
- R3: While bit 0 (enable) of word 2 is set, the counter advances by exactly one per clock. While it is clear, the counter holds its value.
- R4: Word 4 (low half) and word 5 (high half) write the counter only while it is halted. Writes to them while it runs have no effect.
- R5: Channel n's registers sit at word 8+4n (config), 8+4n+1 (comparator low) and 8+4n+2 (comparator high). In one-shot mode (config bit 1 = 0) an enabled channel (config bit 0) sets status bit n in the cycle after the counter equals its comparator, and it fires only once.
- R6: A channel with config bit 0 clear never sets its status bit or its interrupt.
- R7: With config bit 2 (set-value) written to 1, the next write to comparator low loads the comparator and the write after that loads the period. Bit 2 then reads 0.
- R8: In periodic mode (config bit 1 = 1) each match adds the period to the comparator and sets the status bit again.
- R9: With config bit 3 (32-bit mode) set, the match uses only the low 32 counter bits, and the periodic add wraps within the low 32 comparator bits.
- R10: The status word holds one level bit per channel. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R11: Config bits [6:4] select a general line. A channel's interrupt (status AND enable) drives `irq_line_o[route]`. When bit 1 of word 2 (legacy) is set, channel 0 drives only `irq_tick_o` and channel 1 drives only `irq_rtc_o`. When legacy is clear, both of those outputs stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_tick_o | output | 1 | Legacy system-tick interrupt |
| irq_rtc_o | output | 1 | Legacy real-time-clock interrupt |
| irq_line_o | output | NLINES | General interrupt lines |

## Verification
The comparator function is tried with three counter set-ups. The first is a 64-bit run from zero that mixes a one-shot channel, a disabled channel and a periodic channel, which tells apart single firing, suppression and period reload. The second is a legacy-routed run, which separates the dedicated lines from the route field. The third starts the counter just below a 32-bit wrap with its high half nonzero, which tells 32-bit matching and wrapping reload apart from a full 64-bit compare on a neighbouring channel. Every rising interrupt edge is matched against a scoreboard entry that holds the predicted cycle, so an early, late, extra or missing event is caught.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
  localparam int DW    = 32;
  localparam int CNT_W = 64;
  // word addresses
  localparam int A_ID     = 0;
  localparam int A_TICK   = 1;
  localparam int A_GCFG   = 2;
  localparam int A_STS    = 3;
  localparam int A_CLO    = 4;
  localparam int A_CHI    = 5;
  localparam int A_CHBASE = 8;
  // channel config bit positions
  localparam int C_EN  = 0;
  localparam int C_PER = 1;
  localparam int C_SV  = 2;
  localparam int C_F32 = 3;
  localparam int C_RT  = 4;
  localparam int ID_LEG = 8;
endpackage

// File: rtl/evt_tmr_counter.sv
module evt_tmr_counter
  import evt_tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic [DW-1:0]    wdata,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_o <= '0;
    else if (run_i) cnt_o <= cnt_o + 1'b1;
    else if (lo_we) cnt_o[31:0]  <= wdata;
    else if (hi_we) cnt_o[63:32] <= wdata;
  end

  // R3: holds while halted and not written
  p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !lo_we && !hi_we) |=> $stable(cnt_o));
  // R3/R4: running means a clean +1 step, counter writes have no effect
  p_run_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> (cnt_o == $past(cnt_o) + 64'd1));
endmodule

// File: rtl/evt_tmr_channel.sv
module evt_tmr_channel
  import evt_tmr_pkg::*;
#(
  parameter int RTW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             run_i,
  input  logic             cfg_we,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic [DW-1:0]    wdata,
  input  logic             sts_clr,
  output logic [DW-1:0]    cfg_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             sts_o,
  output logic             irq_o,
  output logic [RTW-1:0]   route_o
);
  logic             en_q, per_q, sv_q, f32_q, sv_ph_q;
  logic [CNT_W-1:0] prd_q;
  logic             match, fire;

  assign match = run_i && (f32_q ? (cnt_i[31:0] == cmp_o[31:0]) : (cnt_i == cmp_o));
  assign fire  = match && en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; per_q <= 1'b0; sv_q <= 1'b0; f32_q <= 1'b0; sv_ph_q <= 1'b0;
      route_o <= '0; cmp_o <= '0; prd_q <= '0;
    end else if (cfg_we) begin
      en_q    <= wdata[C_EN];
      per_q   <= wdata[C_PER];
      sv_q    <= wdata[C_SV];
      f32_q   <= wdata[C_F32];
      route_o <= wdata[C_RT +: RTW];
      sv_ph_q <= 1'b0;
    end else if (lo_we) begin
      if (sv_q && sv_ph_q) begin
        prd_q[31:0] <= wdata;
        sv_q        <= 1'b0;
        sv_ph_q     <= 1'b0;
      end else begin
        cmp_o[31:0] <= wdata;
        if (sv_q) sv_ph_q <= 1'b1;
      end
    end else if (hi_we) begin
      if (sv_q && sv_ph_q) prd_q[63:32] <= wdata;
      else                 cmp_o[63:32] <= wdata;
    end else if (fire && per_q) begin
      if (f32_q) cmp_o[31:0] <= cmp_o[31:0] + prd_q[31:0];
      else       cmp_o       <= cmp_o + prd_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       sts_o <= 1'b0;
    else if (fire)    sts_o <= 1'b1;
    else if (sts_clr) sts_o <= 1'b0;
  end

  assign irq_o = sts_o && en_q;
  assign cfg_o = DW'({route_o, f32_q, sv_q, per_q, en_q});

  // R7: second write of the set-value sequence ends it
  p_sv_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we && sv_q && sv_ph_q) |=> !sv_q);
  // R6: a disabled channel never raises status
  p_dis_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !sts_o) |=> !sts_o);
  // R9: 32-bit reload leaves the high comparator half alone
  p_wrap32_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && per_q && f32_q && !cfg_we && !lo_we && !hi_we)
      |=> (cmp_o[63:32] == $past(cmp_o[63:32])));
endmodule

// File: rtl/evt_tmr_route.sv
module evt_tmr_route #(
  parameter int NCH    = 3,
  parameter int NLINES = 8,
  parameter int RTW    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      legacy_i,
  input  logic [NCH-1:0]            irq_i,
  input  logic [NCH-1:0][RTW-1:0]   route_i,
  output logic                      tick_o,
  output logic                      rtc_o,
  output logic [NLINES-1:0]         line_o
);
  assign tick_o = legacy_i && irq_i[0];
  assign rtc_o  = legacy_i && irq_i[1];

  always_comb begin
    line_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (!(legacy_i && c < 2))
        line_o[route_i[c]] = line_o[route_i[c]] | irq_i[c];
    end
  end

  // R11: the dedicated lines stay low outside legacy mode
  p_legacy_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !legacy_i |-> (!tick_o && !rtc_o));
endmodule

// File: rtl/cmp_event_timer.sv
module cmp_event_timer
  import evt_tmr_pkg::*;
#(
  parameter int          NCH     = 3,
  parameter int          NLINES  = 8,
  parameter int          AW      = 8,
  parameter logic [31:0] TICK_FS = 32'd10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_tick_o,
  output logic              irq_rtc_o,
  output logic [NLINES-1:0] irq_line_o
);
  localparam int RTW = $clog2(NLINES);

  logic                    g_en, g_leg;
  logic [CNT_W-1:0]        cnt;
  logic [NCH-1:0][DW-1:0]  ch_cfg;
  logic [NCH-1:0][CNT_W-1:0] ch_cmp;
  logic [NCH-1:0]          ch_sts, ch_irq;
  logic [NCH-1:0][RTW-1:0] ch_rt;

  function automatic logic hit(input logic [AW-1:0] a, input int w);
    return a == AW'(w);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_en  <= 1'b0;
      g_leg <= 1'b0;
    end else if (bus_wr && hit(bus_addr, A_GCFG)) begin
      g_en  <= bus_wdata[0];
      g_leg <= bus_wdata[1];
    end
  end

  evt_tmr_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(g_en),
    .lo_we(bus_wr && hit(bus_addr, A_CLO)),
    .hi_we(bus_wr && hit(bus_addr, A_CHI)),
    .wdata(bus_wdata), .cnt_o(cnt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int B = A_CHBASE + 4 * i;
    evt_tmr_channel #(.RTW(RTW)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .run_i(g_en),
      .cfg_we(bus_wr && hit(bus_addr, B)),
      .lo_we (bus_wr && hit(bus_addr, B + 1)),
      .hi_we (bus_wr && hit(bus_addr, B + 2)),
      .wdata(bus_wdata),
      .sts_clr(bus_wr && hit(bus_addr, A_STS) && bus_wdata[i]),
      .cfg_o(ch_cfg[i]), .cmp_o(ch_cmp[i]), .sts_o(ch_sts[i]),
      .irq_o(ch_irq[i]), .route_o(ch_rt[i])
    );
  end

  evt_tmr_route #(.NCH(NCH), .NLINES(NLINES), .RTW(RTW)) u_route (
    .clk(clk), .rst_n(rst_n), .legacy_i(g_leg), .irq_i(ch_irq), .route_i(ch_rt),
    .tick_o(irq_tick_o), .rtc_o(irq_rtc_o), .line_o(irq_line_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, A_ID))   bus_rdata = DW'(NCH - 1) | (DW'(1) << ID_LEG);
    if (hit(bus_addr, A_TICK)) bus_rdata = TICK_FS;
    if (hit(bus_addr, A_GCFG)) bus_rdata = DW'({g_leg, g_en});
    if (hit(bus_addr, A_STS))  bus_rdata = DW'(ch_sts);
    if (hit(bus_addr, A_CLO))  bus_rdata = cnt[31:0];
    if (hit(bus_addr, A_CHI))  bus_rdata = cnt[63:32];
    for (int i = 0; i < NCH; i++) begin
      if (hit(bus_addr, A_CHBASE + 4 * i))     bus_rdata = ch_cfg[i];
      if (hit(bus_addr, A_CHBASE + 4 * i + 1)) bus_rdata = ch_cmp[i][31:0];
      if (hit(bus_addr, A_CHBASE + 4 * i + 2)) bus_rdata = ch_cmp[i][63:32];
    end
  end

  // R10: a W1C write clears a status bit unless a match sets it again
  p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit(bus_addr, A_STS) && bus_wdata[0] && !g_en) |=> !ch_sts[0]);
endmodule

// File: tb/test_cmp_event_timer.sv
`timescale 1ns/1ps
module test_cmp_event_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_tick_o, irq_rtc_o;
  logic [7:0]  irq_line_o;

  int errors = 0, checks = 0, cyc = 0;
  int q_bit[$], q_cyc[$];
  logic [9:0] obs, prev_obs = '0;
  logic [31:0] rv;
  int n0, n1, n2, h;

  cmp_event_timer i_cmp_event_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_tick_o(irq_tick_o),
    .irq_rtc_o(irq_rtc_o), .irq_line_o(irq_line_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign obs = {irq_rtc_o, irq_tick_o, irq_line_o};

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'(a);
    #1 d = bus_rdata;
  endtask

  task automatic expect_ev(input int b, input int c);
    q_bit.push_back(b); q_cyc.push_back(c);
  endtask

  // idle cycles; optionally clear any raised status at once
  task automatic run_cycles(input int n, input bit clr);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (clr && |obs) begin
        bus_wr = 1'b1; bus_addr = 8'd3; bus_wdata = 32'hFF;
      end else bus_wr = 1'b0;
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // monitor: every rising interrupt edge must match the scoreboard head
  always @(negedge clk) begin
    if (rst_n) begin
      for (int b = 0; b < 10; b++) begin
        if (obs[b] && !prev_obs[b]) begin
          checks++;
          if (q_bit.size() == 0) begin
            errors++;
            $display("FAIL R5/R8/R11: unexpected edge on output %0d at cycle %0d (expected none)", b, cyc);
          end else begin
            int eb, ec;
            eb = q_bit.pop_front(); ec = q_cyc.pop_front();
            if (eb != b || ec != cyc) begin
              errors++;
              $display("FAIL R5/R8/R9/R11: edge output %0d cycle %0d, expected output %0d cycle %0d",
                       b, cyc, eb, ec);
            end
          end
        end
      end
    end
    prev_obs <= obs;
  end

  initial begin
    #(8 * 20000);
    errors++; checks++;
    $display("FAIL watchdog R1: run did not end, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(4, rv); chk(rv, 0, "R1 counter low");
    rd(2, rv); chk(rv, 0, "R1 gcfg");
    rd(3, rv); chk(rv, 0, "R1 status");
    chk(32'(obs), 0, "R1 interrupt outputs");
    // R2 identification and tick length
    rd(0, rv); chk(rv, 32'h102, "R2 id word");
    rd(1, rv); chk(rv, 32'd10_000_000, "R2 tick fs");
    // R4 counter written while halted
    wr(4, 32'h100); wr(5, 32'h2);
    rd(4, rv); chk(rv, 32'h100, "R4 halted write low");
    rd(5, rv); chk(rv, 32'h2, "R4 halted write high");
    wr(4, 0); wr(5, 0);

    // phase A: one-shot ch0, disabled ch1, periodic ch2 (64-bit)
    wr(8, 32'h31);  wr(9, 30);
    wr(12, 32'h40); wr(13, 30);
    wr(16, 32'h57); wr(17, 10); wr(17, 25);
    rd(16, rv); chk(rv, 32'h53, "R7 set-value bit self-clears");
    rd(17, rv); chk(rv, 10, "R7 first write is comparator");
    wr(2, 1); n0 = cyc;
    expect_ev(5, n0 + 11); expect_ev(3, n0 + 31);
    expect_ev(5, n0 + 36); expect_ev(5, n0 + 61);
    run_cycles(35, 1'b1);
    wr(4, 32'hDEAD);            // ignored while running (R4)
    run_cycles(34, 1'b1);
    wr(2, 0); h = cyc;
    rd(4, rv); chk(rv, 32'(h - n0), "R3/R4 count while running");
    run_cycles(5, 1'b0);
    rd(4, rv); chk(rv, 32'(h - n0), "R3 hold while halted");
    rd(18, rv); chk(rv, 0, "R8 comparator high");
    rd(17, rv); chk(rv, 85, "R8 comparator advanced by period");
    rd(3, rv); chk(rv & 32'h2, 0, "R6 disabled channel status");

    // phase B: legacy routing
    wr(4, 0); wr(5, 0);
    wr(8, 32'h01);  wr(9, 8);
    wr(12, 32'h31); wr(13, 12);
    wr(16, 0); wr(3, 32'hFF);
    wr(2, 3); n1 = cyc;
    expect_ev(8, n1 + 9); expect_ev(9, n1 + 13);
    run_cycles(20, 1'b0);
    rd(3, rv); chk(rv, 32'h3, "R5 one-shot status bits");
    chk(32'(irq_line_o), 0, "R11 legacy channels off general lines");
    wr(3, 32'h1);
    rd(3, rv); chk(rv, 32'h2, "R10 W1C clears only bit 0");
    chk({30'd0, irq_rtc_o, irq_tick_o}, 32'h2, "R10/R11 tick dropped rtc held");
    wr(3, 32'h2);
    wr(2, 0);

    // phase C: 32-bit mode near wrap, high half nonzero
    wr(5, 1); wr(4, 32'hFFFF_FFF0);
    wr(16, 32'h6F); wr(17, 32'hFFFF_FFF8); wr(17, 32'h10);
    wr(2, 1); n2 = cyc;
    expect_ev(6, n2 + 9); expect_ev(6, n2 + 25);
    run_cycles(30, 1'b1);
    wr(2, 0);
    rd(17, rv); chk(rv, 32'h18, "R9 wrapped 32-bit reload");
    rd(18, rv); chk(rv, 0, "R9 high comparator untouched");

    chk(32'(q_bit.size()), 0, "R5/R8 all expected events seen");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule